// File: doc/BRIEF.md
# Processor Status Register with Context Save and Restore

This block holds the 16-bit processor status word. The upper byte is the mode byte: the loop flag, a five-bit program-extension field and a two-bit interrupt mask. The lower byte is the condition-code byte: carry, overflow, zero and negative, plus four general flags. The word changes in four ways. The control path can write either byte directly. The ALU can update selected flags through a per-bit enable mask. The loop sequencer can set or clear the loop flag.

On a subroutine call or interrupt entry, the block presents the current word so that the surrounding logic can push it onto the software stack. On a return, the popped word comes back in through the restore port. A return from interrupt reloads all sixteen bits. A return from subroutine takes only the program-extension field from the popped word and keeps every other bit as it was. The stack memory, flag computation and interrupt arbitration are outside this block.

Updates that arrive in the same cycle are resolved by a fixed priority. Reset wins over restore, restore over a direct byte write, a mode-byte write over a loop-flag update, and a condition-code write over an ALU update.

Top module: `psr_core`

## Requirements
- R1: Reset forces the word to 16'h0300: interrupt mask bits 9:8 set to 1, and the loop flag, the program-extension field and all condition-code bits cleared.
- R2: Field positions: loop flag at bit 15, program extension at bits 14:10, interrupt mask at bits 9:8, and in the condition-code byte C at bit 0, V at bit 1, Z at bit 2, N at bit 3, with general flags at bits 7:4.
- R3: With wr_mode_en high, bits 15:8 load wr_data[15:8] at the next clock edge. With wr_cc_en high, bits 7:0 load wr_data[7:0]. Each enable touches only its own byte.
- R4: With alu_upd_en high, each condition-code bit i whose alu_mask[i] is 1 takes alu_flags[i], and each bit whose mask is 0 keeps its value.
- R5: With lf_upd_en high, bit 15 takes lf_val and all other bits are kept.
- R6: With rest_en high and rest_is_int high (return from interrupt), all 16 bits load rest_word.
- R7: With rest_en high and rest_is_int low (return from subroutine), only bits 14:10 load from rest_word and all other bits keep their values.
- R8: Priority in one cycle: a restore overrides every other update for the whole word. wr_mode_en overrides lf_upd_en. wr_cc_en overrides alu_upd_en. Updates to different bytes from different sources both take effect.
- R9: save_valid equals save_req in the same cycle. While save_req is high, save_word shows the current word; otherwise save_word is zero.
- R10: The condition-code byte keeps its value in any cycle without wr_cc_en, alu_upd_en or an interrupt restore, including cycles with only a mode write or loop-flag update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_mode_en | input | 1 | Direct write of the mode byte |
| wr_cc_en | input | 1 | Direct write of the condition-code byte |
| wr_data | input | 16 | Data for direct byte writes |
| alu_upd_en | input | 1 | ALU flag update strobe |
| alu_mask | input | 8 | Per-bit enable for the ALU update |
| alu_flags | input | 8 | New flag values from the ALU |
| lf_upd_en | input | 1 | Loop-flag update strobe |
| lf_val | input | 1 | New loop-flag value |
| rest_en | input | 1 | Restore strobe on return |
| rest_is_int | input | 1 | 1: interrupt return (full), 0: subroutine return (extension only) |
| rest_word | input | 16 | Word popped from the stack |
| save_req | input | 1 | Subroutine call or interrupt entry |
| save_valid | output | 1 | Saved word is valid |
| save_word | output | 16 | Word to be pushed |
| sr_q | output | 16 | Current status word |

## Verification
The restore path is driven twice in subroutine mode: once with an all-zero popped word and once with an all-ones popped word. Together these show that only bits 14:10 follow the input and that the loop flag, mask and flags are untouched. An interrupt restore with a mixed pattern checks the full reload. ALU updates use masks covering only the low nibble, only the high nibble and no bits, which separates masked from unmasked bits. Paired strobes in a single cycle (mode write with loop flag, byte write with ALU, restore with everything) check each priority link.

// File: rtl/psr_pkg.sv
package psr_pkg;
   // contiguous bit mask of width w starting at lsb
   function automatic logic [31:0] field_mask(input int lsb, input int w);
      return ((32'd1 << w) - 32'd1) << lsb;
   endfunction
endpackage

// File: rtl/psr_mode_byte.sv
module psr_mode_byte #(
   parameter int MB_W      = 8,
   parameter int LF_POS    = 7,
   parameter int PX_LSB    = 2,
   parameter int PX_W      = 5,
   parameter int IM_LSB    = 0,
   parameter int IM_W      = 2,
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rest_en,
   input  logic            rest_full,
   input  logic [MB_W-1:0] rest_byte,
   input  logic            wr_en,
   input  logic [MB_W-1:0] wr_byte,
   input  logic            lf_en,
   input  logic            lf_val,
   output logic [MB_W-1:0] q
);
   localparam logic [MB_W-1:0] PX_MASK = MB_W'(psr_pkg::field_mask(PX_LSB, PX_W));
   localparam logic [MB_W-1:0] IM_MASK = MB_W'(psr_pkg::field_mask(IM_LSB, IM_W));
   localparam logic [MB_W-1:0] LF_MASK = MB_W'(psr_pkg::field_mask(LF_POS, 1));
   localparam logic [MB_W-1:0] RST_VAL = IM_MASK;

   if (PX_LSB + PX_W > MB_W) begin : g_px_range_bad
      $error("extension field does not fit the mode byte");
   end
   if (IM_LSB + IM_W > MB_W) begin : g_im_range_bad
      $error("interrupt mask does not fit the mode byte");
   end
   if ((PX_MASK & IM_MASK) != '0 || ((PX_MASK | IM_MASK) & LF_MASK) != '0) begin : g_overlap_bad
      $error("mode byte fields overlap");
   end

   logic [MB_W-1:0] d;

   always_comb begin
      d = q;
      if (rest_en) begin
         d = rest_full ? rest_byte : ((q & ~PX_MASK) | (rest_byte & PX_MASK));
      end else if (wr_en) begin
         d = wr_byte;
      end else if (lf_en) begin
         d[LF_POS] = lf_val;
      end
   end

   if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= RST_VAL;
         else        q <= d;
      end
   end else begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n) q <= RST_VAL;
         else        q <= d;
      end
   end

   AST_MODE_RESET: assert property (@(posedge clk) !rst_n |=> q == RST_VAL); // R1

   AST_MODE_SUB_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      rest_en && !rest_full |=> (q & ~PX_MASK) == ($past(q) & ~PX_MASK)); // R7

   AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !rest_en |=> q == $past(wr_byte)); // R3

   AST_MODE_LOOP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      lf_en && !wr_en && !rest_en |=>
         (q[LF_POS] == $past(lf_val)) && ((q & ~LF_MASK) == ($past(q) & ~LF_MASK))); // R5
endmodule

// File: rtl/psr_cc_byte.sv
module psr_cc_byte #(
   parameter int CB_W      = 8,
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rest_en,
   input  logic            rest_full,
   input  logic [CB_W-1:0] rest_byte,
   input  logic            wr_en,
   input  logic [CB_W-1:0] wr_byte,
   input  logic            alu_en,
   input  logic [CB_W-1:0] alu_mask,
   input  logic [CB_W-1:0] alu_flags,
   output logic [CB_W-1:0] q
);
   if (CB_W < 4) begin : g_width_bad
      $error("condition-code byte needs room for C, V, Z and N");
   end

   logic [CB_W-1:0] d;

   for (genvar i = 0; i < CB_W; i++) begin : g_bit
      always_comb begin
         if (rest_en)                   d[i] = rest_full ? rest_byte[i] : q[i];
         else if (wr_en)                d[i] = wr_byte[i];
         else if (alu_en && alu_mask[i]) d[i] = alu_flags[i];
         else                           d[i] = q[i];
      end
   end

   if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end
   end else begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end
   end

   AST_CC_RESET: assert property (@(posedge clk) !rst_n |=> q == '0); // R1

   AST_CC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rest_en && rest_full) && !wr_en && !alu_en |=> $stable(q)); // R10

   AST_CC_ALU_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      alu_en && !wr_en && !rest_en |=>
         (q & ~$past(alu_mask)) == ($past(q) & ~$past(alu_mask))); // R4

   AST_CC_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !rest_en |=> q == $past(wr_byte)); // R8
endmodule

// File: rtl/psr_core.sv
module psr_core #(
   parameter int SR_W      = 16,
   parameter int MODE_LSB  = 8,
   parameter int LF_BIT    = 15,
   parameter int PX_LSB    = 10,
   parameter int PX_W      = 5,
   parameter int IM_LSB    = 8,
   parameter int IM_W      = 2,
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_mode_en,
   input  logic                     wr_cc_en,
   input  logic [SR_W-1:0]          wr_data,
   input  logic                     alu_upd_en,
   input  logic [MODE_LSB-1:0]      alu_mask,
   input  logic [MODE_LSB-1:0]      alu_flags,
   input  logic                     lf_upd_en,
   input  logic                     lf_val,
   input  logic                     rest_en,
   input  logic                     rest_is_int,
   input  logic [SR_W-1:0]          rest_word,
   input  logic                     save_req,
   output logic                     save_valid,
   output logic [SR_W-1:0]          save_word,
   output logic [SR_W-1:0]          sr_q
);
   localparam int CC_W   = MODE_LSB;
   localparam int MODE_W = SR_W - MODE_LSB;

   if (MODE_W < 1 || CC_W < 1) begin : g_split_bad
      $error("status word must split into two non-empty bytes");
   end
   if (LF_BIT < MODE_LSB || PX_LSB < MODE_LSB || IM_LSB < MODE_LSB) begin : g_field_bad
      $error("mode fields must sit in the upper part of the word");
   end

   logic [MODE_W-1:0] mode_q;
   logic [CC_W-1:0]   cc_q;

   psr_mode_byte #(
      .MB_W      (MODE_W),
      .LF_POS    (LF_BIT - MODE_LSB),
      .PX_LSB    (PX_LSB - MODE_LSB),
      .PX_W      (PX_W),
      .IM_LSB    (IM_LSB - MODE_LSB),
      .IM_W      (IM_W),
      .ASYNC_RST (ASYNC_RST)
   ) u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .rest_en   (rest_en),
      .rest_full (rest_is_int),
      .rest_byte (rest_word[SR_W-1:MODE_LSB]),
      .wr_en     (wr_mode_en),
      .wr_byte   (wr_data[SR_W-1:MODE_LSB]),
      .lf_en     (lf_upd_en),
      .lf_val    (lf_val),
      .q         (mode_q)
   );

   psr_cc_byte #(
      .CB_W      (CC_W),
      .ASYNC_RST (ASYNC_RST)
   ) u_cc (
      .clk       (clk),
      .rst_n     (rst_n),
      .rest_en   (rest_en),
      .rest_full (rest_is_int),
      .rest_byte (rest_word[MODE_LSB-1:0]),
      .wr_en     (wr_cc_en),
      .wr_byte   (wr_data[MODE_LSB-1:0]),
      .alu_en    (alu_upd_en),
      .alu_mask  (alu_mask),
      .alu_flags (alu_flags),
      .q         (cc_q)
   );

   assign sr_q       = {mode_q, cc_q};
   assign save_valid = save_req;
   assign save_word  = save_req ? sr_q : '0;

   AST_INT_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      rest_en && rest_is_int |=> sr_q == $past(rest_word)); // R6

   AST_SUB_RESTORE_CC: assert property (@(posedge clk) disable iff (!rst_n)
      rest_en && !rest_is_int |=> cc_q == $past(cc_q)); // R7
endmodule

// File: tb/psr_core_tb.sv
module psr_core_tb_top;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_mode_en = 1'b0, wr_cc_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        alu_upd_en = 1'b0;
   logic [7:0]  alu_mask = '0, alu_flags = '0;
   logic        lf_upd_en = 1'b0, lf_val = 1'b0;
   logic        rest_en = 1'b0, rest_is_int = 1'b0;
   logic [15:0] rest_word = '0;
   logic        save_req = 1'b0;
   logic        save_valid;
   logic [15:0] save_word, sr_q;

   int checks = 0;
   int errors = 0;
   logic [15:0] model = 16'h0300;
   logic [15:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_P/2) clk = ~clk;

   psr_core dut_i (
      .clk(clk), .rst_n(rst_n),
      .wr_mode_en(wr_mode_en), .wr_cc_en(wr_cc_en), .wr_data(wr_data),
      .alu_upd_en(alu_upd_en), .alu_mask(alu_mask), .alu_flags(alu_flags),
      .lf_upd_en(lf_upd_en), .lf_val(lf_val),
      .rest_en(rest_en), .rest_is_int(rest_is_int), .rest_word(rest_word),
      .save_req(save_req), .save_valid(save_valid), .save_word(save_word),
      .sr_q(sr_q)
   );

   task automatic check16(input string tag, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // driver: applies one cycle of stimulus and queues the expected word
   task automatic step(input logic wm, input logic wc, input logic [15:0] wd,
                       input logic au, input logic [7:0] am, input logic [7:0] af,
                       input logic lu, input logic lv,
                       input logic re, input logic ri, input logic [15:0] rw,
                       input string tag);
      logic [7:0] md, cc;
      @(negedge clk);
      wr_mode_en = wm; wr_cc_en = wc; wr_data = wd;
      alu_upd_en = au; alu_mask = am; alu_flags = af;
      lf_upd_en = lu; lf_val = lv;
      rest_en = re; rest_is_int = ri; rest_word = rw;
      md = model[15:8];
      cc = model[7:0];
      if (re) begin
         if (ri) model = rw;
         else    model = (model & ~16'h7C00) | (rw & 16'h7C00);
      end else begin
         if (wm)      md = wd[15:8];
         else if (lu) md[7] = lv;
         if (wc)      cc = wd[7:0];
         else if (au) cc = (cc & ~am) | (af & am);
         model = {md, cc};
      end
      exp_q.push_back(model);
      tag_q.push_back(tag);
   endtask

   task automatic idle(input string tag);
      step(0, 0, 16'h0, 0, 8'h0, 8'h0, 0, 0, 0, 0, 16'h0, tag);
   endtask

   task automatic check_save(input string tag);
      @(negedge clk);
      idle_inputs();
      save_req = 1'b1;
      #1;
      check16(tag, {15'd0, save_valid}, 16'd1);
      check16(tag, save_word, model);
      save_req = 1'b0;
      #1;
      check16(tag, {15'd0, save_valid}, 16'd0);
      check16(tag, save_word, 16'h0000);
   endtask

   task automatic idle_inputs();
      wr_mode_en = 0; wr_cc_en = 0; alu_upd_en = 0; lf_upd_en = 0; rest_en = 0;
   endtask

   // monitor: pops expected words after each clock edge
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_P/4);
         if (exp_q.size() > 0) begin
            check16(tag_q.pop_front(), sr_q, exp_q.pop_front());
         end
      end
   end

   initial begin
      #(CLK_P * 20000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check16("R1 reset value during reset", sr_q, 16'h0300);
      rst_n = 1'b1;
      @(negedge clk);
      check16("R1 reset value after release", sr_q, 16'h0300);
      check_save("R9 save of reset word");

      step(1, 0, 16'hA53C, 0, 8'h00, 8'h00, 0, 0, 0, 0, 16'h0, "R3 mode byte write");
      step(0, 1, 16'h1234, 0, 8'h00, 8'h00, 0, 0, 0, 0, 16'h0, "R3 cc byte write");
      step(1, 1, 16'h5AC3, 0, 8'h00, 8'h00, 0, 0, 0, 0, 16'h0, "R3 both bytes");
      step(0, 0, 16'hFFFF, 1, 8'h0F, 8'h0A, 0, 0, 0, 0, 16'h0, "R4 low nibble mask");
      step(0, 0, 16'h0000, 1, 8'hF0, 8'hFF, 0, 0, 0, 0, 16'h0, "R4 high nibble mask");
      step(0, 0, 16'h0000, 1, 8'h00, 8'h55, 0, 0, 0, 0, 16'h0, "R4 empty mask");
      step(0, 1, 16'h0000, 0, 8'h00, 8'h00, 0, 0, 0, 0, 16'h0, "R2 clear cc");
      step(0, 0, 16'h0000, 1, 8'h01, 8'h01, 0, 0, 0, 0, 16'h0, "R2 carry at bit 0");
      step(0, 0, 16'h0000, 1, 8'h08, 8'h08, 0, 0, 0, 0, 16'h0, "R2 negative at bit 3");
      step(0, 0, 16'h0000, 0, 8'h00, 8'h00, 1, 1, 0, 0, 16'h0, "R5 loop flag set");
      step(0, 0, 16'h0000, 0, 8'h00, 8'h00, 1, 0, 0, 0, 16'h0, "R5 loop flag clear");
      step(0, 0, 16'h0000, 0, 8'h00, 8'h00, 1, 1, 0, 0, 16'h0, "R10 cc kept on loop update");
      step(1, 0, 16'h4200, 0, 8'h00, 8'h00, 1, 1, 0, 0, 16'h0, "R8 mode write over loop flag");
      step(0, 1, 16'h0077, 1, 8'hFF, 8'h00, 0, 0, 0, 0, 16'h0, "R8 cc write over alu");
      step(1, 0, 16'h9100, 1, 8'hF0, 8'hA0, 0, 0, 0, 0, 16'h0, "R8 mode write with alu");
      idle("R10 idle hold");
      step(0, 0, 16'h0000, 0, 8'h00, 8'h00, 0, 0, 1, 1, 16'hBEEF, "R6 interrupt restore");
      step(0, 0, 16'h0000, 0, 8'h00, 8'h00, 0, 0, 1, 0, 16'h0000, "R7 subroutine restore zeros");
      step(0, 0, 16'h0000, 0, 8'h00, 8'h00, 0, 0, 1, 0, 16'hFFFF, "R7 subroutine restore ones");
      step(1, 1, 16'h1111, 1, 8'hFF, 8'h00, 1, 0, 1, 0, 16'h0000, "R8 restore over all");
      step(1, 1, 16'h2222, 1, 8'hFF, 8'hFF, 1, 1, 1, 1, 16'h6C35, "R8 interrupt restore over all");
      idle("R10 final idle");
      check_save("R9 save after updates");
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule